// File: doc/BRIEF.md
# Content Addressable Lookup Table

The block is a small, fully associative tag store owned by a single processing engine. A lookup presents a 32-bit key. The key is compared against all sixteen entries in one step. The answer comes back one cycle later.

When an entry matches, the answer gives its index and the 4-bit state value stored with it. When nothing matches, the answer names the entry that should be evicted. Software can pass that index straight to the write port to install the new key.

Eviction follows least recently used order, with never-written entries used first. A separate write port loads any entry with a tag and a state value. A write and a lookup may arrive in the same cycle.

Top module: `cam_lookup_table`

## Requirements
- R1: After reset, rsp_valid is 0 and every entry is invalid, so the first lookup misses with rsp_idx = 0.
- R2: A write stores wr_tag and wr_state in entry wr_idx and marks it valid. A later lookup of that tag returns rsp_hit = 1, rsp_idx = wr_idx and rsp_state = the stored state.
- R3: rsp_valid is 1 exactly in the cycle after a cycle with lkp_req = 1. The response fields are registered and are valid in that cycle.
- R4: On a miss, rsp_hit = 0, rsp_state = 0, and rsp_idx names the replacement victim.
- R5: While any entry is invalid, the victim is the lowest-indexed invalid entry.
- R6: When all entries are valid, the victim is the least recently used entry.
- R7: A write to an entry and a lookup hit on an entry each make that entry the most recently used.
- R8: If the key matches several valid entries, the lowest index is reported.
- R9: A write and a lookup in the same cycle are ordered write first. The lookup sees the new tag, state and validity, and on a miss it sees the recency update caused by the write.
- R10: The full 4-bit state range is kept, including the value 15.
- R11: An invalid entry never produces a hit, whatever its tag bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_req | input | 1 | Lookup request |
| lkp_key | input | 32 | Lookup key |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Entry to write |
| wr_tag | input | 32 | Tag to store |
| wr_state | input | 4 | State value to store |
| rsp_valid | output | 1 | Response valid, one cycle after lkp_req |
| rsp_hit | output | 1 | 1 on a hit, 0 on a miss |
| rsp_idx | output | 4 | Matching entry on a hit, victim entry on a miss |
| rsp_state | output | 4 | State of the matching entry, 0 on a miss |

## Verification
A corrupted valid bit or tag becomes visible at the next lookup of that key, one cycle after the request. It shows as a wrong hit flag, a wrong index or a wrong victim.

A corrupted recency order stays hidden while any entry is still invalid. It appears only once the table is full, as a wrong victim index on the first miss after that. For this reason the bench fills the table completely and then issues many misses interleaved with hits and writes.

// File: rtl/cam_lkp_pkg.sv
`timescale 1ns/1ps
package cam_lkp_pkg;
  localparam int unsigned CAM_ENTRIES = 16;
  localparam int unsigned CAM_TAG_W   = 32;
  localparam int unsigned CAM_STATE_W = 4;
endpackage

// File: rtl/cam_store.sv
`timescale 1ns/1ps
module cam_store #(
  parameter int unsigned N  = 16,
  parameter int unsigned TW = 32,
  parameter int unsigned SW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [TW-1:0]        wr_tag,
  input  logic [SW-1:0]        wr_state,
  output logic [N-1:0][TW-1:0] tag_eff,
  output logic [N-1:0][SW-1:0] state_eff,
  output logic [N-1:0]         valid_eff,
  output logic [N-1:0]         valid_q
);
  logic [N-1:0][TW-1:0] tag_q;
  logic [N-1:0][SW-1:0] state_q;
  logic [N-1:0]         sel;

  for (genvar g = 0; g < N; g++) begin : g_ent
    // write-first view: the entry being written shows its new contents now
    always_comb begin
      sel[g]       = wr_en && (wr_idx == IW'(g));
      tag_eff[g]   = sel[g] ? wr_tag   : tag_q[g];
      state_eff[g] = sel[g] ? wr_state : state_q[g];
      valid_eff[g] = sel[g] | valid_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        state_q[g] <= '0;
      end else if (sel[g]) begin
        valid_q[g] <= 1'b1;
        state_q[g] <= wr_state;
      end
    end

    always_ff @(posedge clk) begin
      if (sel[g]) tag_q[g] <= wr_tag;
    end
  end
endmodule

// File: rtl/cam_match.sv
`timescale 1ns/1ps
module cam_match #(
  parameter int unsigned N  = 16,
  parameter int unsigned TW = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [TW-1:0]        key,
  input  logic [N-1:0][TW-1:0] tag_eff,
  input  logic [N-1:0]         valid_eff,
  output logic                 hit,
  output logic [IW-1:0]        hit_idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_eff[g] && (tag_eff[g] == key);
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IW'(i);
    end
  end
endmodule

// File: rtl/cam_lru.sv
`timescale 1ns/1ps
module cam_lru #(
  parameter int unsigned N = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          hit_touch,
  input  logic [IW-1:0] hit_idx,
  input  logic [N-1:0]  valid_eff,
  output logic [IW-1:0] victim_idx,
  output logic [N-1:0]  oldest_q
);
  logic [N-1:0][IW-1:0] ages_q, age_w, age_d;
  logic                 age_en;

  // age 0 = most recent, N-1 = least recent; write touch first, then hit touch
  always_comb begin
    age_w = ages_q;
    if (wr_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == wr_idx)               age_w[i] = '0;
        else if (ages_q[i] < ages_q[wr_idx]) age_w[i] = ages_q[i] + 1'b1;
      end
    end
    age_d = age_w;
    if (hit_touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == hit_idx)               age_d[i] = '0;
        else if (age_w[i] < age_w[hit_idx])  age_d[i] = age_w[i] + 1'b1;
      end
    end
    age_en = wr_en | hit_touch;
  end

  always_comb begin
    victim_idx = '0;
    if (~&valid_eff) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (!valid_eff[i]) victim_idx = IW'(i);
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (age_w[i] == IW'(N - 1)) victim_idx = IW'(i);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ages_q[g] <= IW'(g);
      else if (age_en) ages_q[g] <= age_d[g];
    end
    assign oldest_q[g] = (ages_q[g] == IW'(N - 1));
  end
endmodule

// File: rtl/cam_lookup_table.sv
`timescale 1ns/1ps
module cam_lookup_table #(
  parameter int unsigned N  = cam_lkp_pkg::CAM_ENTRIES,
  parameter int unsigned TW = cam_lkp_pkg::CAM_TAG_W,
  parameter int unsigned SW = cam_lkp_pkg::CAM_STATE_W,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lkp_req,
  input  logic [TW-1:0] lkp_key,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag,
  input  logic [SW-1:0] wr_state,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [IW-1:0] rsp_idx,
  output logic [SW-1:0] rsp_state
);
  logic [N-1:0][TW-1:0] tag_eff;
  logic [N-1:0][SW-1:0] state_eff;
  logic [N-1:0]         valid_eff, valid_q, oldest_q;
  logic                 hit;
  logic [IW-1:0]        hit_idx, victim_idx;
  logic                 hit_d;
  logic [IW-1:0]        idx_d;
  logic [SW-1:0]        state_d;

  cam_store #(.N(N), .TW(TW), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_state(wr_state), .tag_eff(tag_eff),
    .state_eff(state_eff), .valid_eff(valid_eff), .valid_q(valid_q)
  );

  cam_match #(.N(N), .TW(TW)) u_match (
    .key(lkp_key), .tag_eff(tag_eff), .valid_eff(valid_eff),
    .hit(hit), .hit_idx(hit_idx)
  );

  cam_lru #(.N(N)) u_lru (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .hit_touch(lkp_req & hit), .hit_idx(hit_idx), .valid_eff(valid_eff),
    .victim_idx(victim_idx), .oldest_q(oldest_q)
  );

  always_comb begin
    hit_d   = hit;
    idx_d   = hit ? hit_idx : victim_idx;
    state_d = hit ? state_eff[hit_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_state <= '0;
    end else begin
      rsp_valid <= lkp_req;
      if (lkp_req) begin
        rsp_hit   <= hit_d;
        rsp_idx   <= idx_d;
        rsp_state <= state_d;
      end
    end
  end
endmodule

// File: rtl/cam_lookup_table_chk.sv
`timescale 1ns/1ps
module cam_lookup_table_chk #(
  parameter int unsigned N  = 16,
  parameter int unsigned TW = 32,
  parameter int unsigned SW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lkp_req,
  input logic [TW-1:0] lkp_key,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [TW-1:0] wr_tag,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [IW-1:0] rsp_idx,
  input logic [SW-1:0] rsp_state,
  input logic [N-1:0]  valid_q,
  input logic [N-1:0]  oldest_q
);
  assert_rsp_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |=> rsp_valid);
  assert_no_rsp_without_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_req |=> !rsp_valid);
  assert_miss_state_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_state == '0));
  assert_write_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]);
  assert_hit_only_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> valid_q[rsp_idx]);
  assert_single_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_q));
  assert_write_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_req && wr_en && lkp_key == wr_tag) |=> rsp_hit);
endmodule

bind cam_lookup_table cam_lookup_table_chk #(.N(N), .TW(TW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lkp_req(lkp_req), .lkp_key(lkp_key),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_state(rsp_state),
  .valid_q(valid_q), .oldest_q(oldest_q)
);

// File: tb/tb_cam_lookup_table.sv
`timescale 1ns/1ps
module tb_cam_lookup_table;
  logic        clk;
  logic        rst_n;
  logic        lkp_req;
  logic [31:0] lkp_key;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_tag;
  logic [3:0]  wr_state;
  logic        rsp_valid, rsp_hit;
  logic [3:0]  rsp_idx, rsp_state;

  cam_lookup_table dut (
    .clk(clk), .rst_n(rst_n), .lkp_req(lkp_req), .lkp_key(lkp_key),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_state(wr_state),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
    .rsp_state(rsp_state)
  );

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  // reference model: contents plus a recency list, most recent first
  logic [31:0] m_tag [16];
  bit          m_val [16];
  logic [3:0]  m_st  [16];
  int          lru [$];
  bit          e_valid, e_hit;
  logic [3:0]  e_idx, e_st;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic touch(input int i);
    for (int k = 0; k < lru.size(); k++) begin
      if (lru[k] == i) begin
        lru.delete(k);
        break;
      end
    end
    lru.push_front(i);
  endtask

  task automatic compare();
    checks++;
    if (rsp_valid !== e_valid ||
        (e_valid && (rsp_hit !== e_hit || rsp_idx !== e_idx || rsp_state !== e_st))) begin
      errors++;
      $display("FAIL %s: actual v=%0b hit=%0b idx=%0d st=%0d expected v=%0b hit=%0b idx=%0d st=%0d",
               phase, rsp_valid, rsp_hit, rsp_idx, rsp_state, e_valid, e_hit, e_idx, e_st);
    end
  endtask

  task automatic cyc(input bit req, input logic [31:0] key, input bit we,
                     input int widx, input logic [31:0] wtag, input logic [3:0] wst);
    int found;
    lkp_req  = req;
    lkp_key  = key;
    wr_en    = we;
    wr_idx   = 4'(widx);
    wr_tag   = wtag;
    wr_state = wst;
    if (we) begin
      m_tag[widx] = wtag;
      m_st[widx]  = wst;
      m_val[widx] = 1'b1;
      touch(widx);
    end
    e_valid = req;
    if (req) begin
      found = -1;
      for (int i = 15; i >= 0; i--) if (m_val[i] && m_tag[i] == key) found = i;
      if (found >= 0) begin
        e_hit = 1'b1;
        e_idx = 4'(found);
        e_st  = m_st[found];
        touch(found);
      end else begin
        e_hit = 1'b0;
        e_st  = 4'd0;
        found = -1;
        for (int i = 15; i >= 0; i--) if (!m_val[i]) found = i;
        e_idx = (found >= 0) ? 4'(found) : 4'(lru[$]);
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic look(input logic [31:0] key);
    cyc(1'b1, key, 1'b0, 0, 32'h0, 4'h0);
  endtask

  task automatic wr(input int idx, input logic [31:0] tag, input logic [3:0] st);
    cyc(1'b0, 32'h0, 1'b1, idx, tag, st);
  endtask

  initial begin
    rst_n = 1'b0; lkp_req = 1'b0; lkp_key = '0; wr_en = 1'b0;
    wr_idx = '0; wr_tag = '0; wr_state = '0;
    for (int i = 0; i < 16; i++) begin
      m_val[i] = 1'b0; m_tag[i] = '0; m_st[i] = '0; lru.push_back(i);
    end
    e_valid = 1'b0; e_hit = 1'b0; e_idx = '0; e_st = '0;
    repeat (3) @(negedge clk);
    phase = "R1 reset idle"; compare();
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1 reset idle"; compare();
    phase = "R1 first miss"; look(32'hDEAD_BEEF);
    phase = "R11 invalid no hit"; look(32'h0);
    phase = "R2 write";
    wr(0, 32'h1000_0000, 4'd3);
    wr(1, 32'h1000_0001, 4'd7);
    wr(2, 32'h1000_0002, 4'd0);
    phase = "R10 state 15"; wr(3, 32'h1000_0003, 4'd15);
    phase = "R2 hit"; look(32'h1000_0001);
    phase = "R10 state 15 hit"; look(32'h1000_0003);
    phase = "R5 lowest invalid"; look(32'h5555_5555);
    phase = "R3 idle"; cyc(1'b0, 32'h1000_0000, 1'b0, 0, 0, 0);
    phase = "R3 idle"; cyc(1'b0, 32'h1000_0000, 1'b0, 0, 0, 0);
    phase = "R4 miss"; look(32'h0BAD_0000);
    phase = "R2 fill";
    for (int i = 4; i < 16; i++) wr(i, 32'h2000_0000 + 32'(i), 4'(i));
    phase = "R6 lru victim"; look(32'h7777_7777);
    phase = "R7 hit touch"; look(32'h1000_0000);
    phase = "R6 lru after touch"; look(32'h7777_7777);
    phase = "R7 write touch"; wr(1, 32'h3000_0001, 4'd9);
    phase = "R6 lru after write"; look(32'h7777_7777);
    phase = "R8 duplicate"; wr(9, 32'h1000_0002, 4'd4);
    phase = "R8 lowest match"; look(32'h1000_0002);
    phase = "R9 write first hit"; cyc(1'b1, 32'h4444_0000, 1'b1, 12, 32'h4444_0000, 4'd6);
    phase = "R9 write first miss"; cyc(1'b1, 32'h2000_0005, 1'b1, 5, 32'h4444_0005, 4'd1);
    phase = "R9 write first victim"; cyc(1'b1, 32'h9999_0000, 1'b1, 3, 32'h4444_0003, 4'd2);
    // randomized mix against the model
    phase = "R6 R7 random mix";
    for (int n = 0; n < 600; n++) begin
      cyc(1'($urandom), 32'h100 + 32'($urandom_range(0, 23)), 1'($urandom_range(0, 3) == 0),
          int'($urandom_range(0, 15)), 32'h100 + 32'($urandom_range(0, 23)), 4'($urandom));
    end
    phase = "R1 reset again";
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) m_val[i] = 1'b0;
    lru.delete();
    for (int i = 0; i < 16; i++) lru.push_back(i);
    @(negedge clk);
    lkp_req = 1'b0; wr_en = 1'b0;
    rst_n = 1'b1;
    e_valid = 1'b0; compare();
    phase = "R1 miss after reset"; look(32'h100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule